// File: doc/BRIEF.md
# Polyphase Interpolate-by-Four FIR Filter

This block raises the sample rate of a signed stream by four. It uses a 16-coefficient low-pass prototype. The prototype is regrouped into four branches of four taps each. Branch p uses the coefficients h(p), h(p+4), h(p+8) and h(p+12). A single 4-tap multiply-accumulate datapath serves all four branches. It runs on the fast clock, and a phase counter presents a different branch's coefficients on each fast cycle. Every input sample therefore yields four output samples, one per branch, in branch order.

The surrounding logic supplies one fast clock and marks each new slow-rate sample with a one-cycle strobe. Coefficients are written one at a time through a small write port, addressed by their prototype index. Each result is rounded from the full-precision accumulator back to the input width and clipped to the signed range.

Top module: `polyphase_interp4`

## Requirements
- R1: While `rst_n` is low and after it is released with no input, `out_valid` is 0 and `out_data` is 0.
- R2: A cycle with `coef_we` high stores `coef_data` as prototype coefficient h(`coef_addr`), with address 0..15. The new value is used by every branch computed from the following cycle on. Cycles with `coef_we` low leave all coefficients unchanged.
- R3: Let the four most recent accepted samples be x0 (newest) through x3. The branch p result is the rounded, saturated value of h(p)·x0 + h(p+4)·x1 + h(p+8)·x2 + h(p+12)·x3.
- R4: When a sample is captured at clock edge E, the branch 0, 1, 2 and 3 results appear on `out_data` after edges E+1, E+2, E+3 and E+4 respectively, each with `out_valid` high.
- R5: The sample history shifts only on a cycle with `in_valid` high. Idle cycles of any length leave it unchanged.
- R6: With `in_valid` asserted exactly every fourth cycle, `out_valid` stays high on every cycle from E+1 of the first sample onward.
- R7: If no new sample arrives, `out_valid` falls after the branch 3 result has been presented for one cycle. `out_data` then holds its last value.
- R8: Rounding is round-half-up at bit 17. The result is floor((sum + 2^16) / 2^17), with products taken as full 36-bit values and the sum carrying two guard bits.
- R9: A rounded result above 131071 is output as 131071, and one below −131072 is output as −131072.
- R10: A strobe that arrives before the four branches have finished restarts the sequence at branch 0 on the new sample history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, four times the input sample rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | One-cycle strobe marking a new input sample |
| in_data | input | 18 | Signed input sample |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | 4 | Prototype coefficient index, 0..15 |
| coef_data | input | 18 | Signed coefficient value |
| out_valid | output | 1 | High on each cycle carrying an output sample |
| out_data | output | 18 | Signed interpolated output sample |

## Verification
The assertions assume that `in_valid` arrives at most once every four cycles in normal streaming. They also assume that coefficients are not rewritten while a sample's four branches are in flight. The phase-restart case is the one deliberate exception. The stimulus loads all coefficients while the datapath is idle. It then streams samples on an exact four-cycle cadence, and inserts long idle gaps and one early strobe only in the directed tests that target history hold and restart.

// File: rtl/interp4_pkg.sv
package interp4_pkg;
  localparam int DEF_DATA_W = 18;
  localparam int DEF_COEF_W = 18;
  localparam int DEF_FACTOR = 4;
  localparam int DEF_TAPS   = 4;
  localparam int DEF_FRAC   = 17;
endpackage

// File: rtl/interp4_coef_bank.sv
module interp4_coef_bank #(
  parameter int COEF_W = 18,
  parameter int FACTOR = 4,
  parameter int TAPS   = 4,
  localparam int NCOEF  = FACTOR * TAPS,
  localparam int ADDR_W = $clog2(NCOEF),
  localparam int PH_W   = $clog2(FACTOR)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [ADDR_W-1:0]      waddr,
  input  logic [COEF_W-1:0]      wdata,
  input  logic [PH_W-1:0]        phase,
  output logic [TAPS*COEF_W-1:0] branch_coefs
);
  logic [NCOEF*COEF_W-1:0] bank_q, bank_d;

  always_comb begin
    bank_d = bank_q;
    if (we) bank_d[waddr*COEF_W +: COEF_W] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else if (we) bank_q <= bank_d;
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_sel
    logic [ADDR_W-1:0] idx;
    assign idx = ADDR_W'(k * FACTOR) + ADDR_W'(phase);
    assign branch_coefs[k*COEF_W +: COEF_W] = bank_q[idx*COEF_W +: COEF_W];
  end

  // R2
  coef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(bank_q));
endmodule

// File: rtl/interp4_tap_line.sv
module interp4_tap_line #(
  parameter int DATA_W = 18,
  parameter int TAPS   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   shift,
  input  logic [DATA_W-1:0]      din,
  output logic [TAPS*DATA_W-1:0] taps
);
  logic [TAPS*DATA_W-1:0] line_q, line_d;

  always_comb begin
    line_d = {line_q[(TAPS-1)*DATA_W-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else if (shift) line_q <= line_d;
  end

  assign taps = line_q;

  // R5
  tap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(line_q));
endmodule

// File: rtl/interp4_phase_ctrl.sv
module interp4_phase_ctrl #(
  parameter int FACTOR = 4,
  localparam int PH_W = $clog2(FACTOR),
  localparam logic [PH_W-1:0] LAST = PH_W'(FACTOR - 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic [PH_W-1:0] phase,
  output logic            run
);
  logic [PH_W-1:0] phase_q, phase_d;
  logic            run_q, run_d;

  always_comb begin
    phase_d = phase_q;
    run_d   = run_q;
    if (start) begin
      phase_d = '0;
      run_d   = 1'b1;
    end else if (run_q) begin
      if (phase_q == LAST) begin
        phase_d = '0;
        run_d   = 1'b0;
      end else begin
        phase_d = phase_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      run_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      run_q   <= run_d;
    end
  end

  assign phase = phase_q;
  assign run   = run_q;

  // R4
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !start && phase_q != LAST) |=> (run_q && phase_q == PH_W'($past(phase_q) + 1'b1)));
  // R10
  phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (run_q && phase_q == '0));
  // R7
  run_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !start && phase_q == LAST) |=> !run_q);
endmodule

// File: rtl/interp4_mac.sv
module interp4_mac #(
  parameter int DATA_W = 18,
  parameter int COEF_W = 18,
  parameter int TAPS   = 4,
  parameter int FRAC   = 17,
  localparam int PROD_W = DATA_W + COEF_W,
  localparam int ACC_W  = PROD_W + $clog2(TAPS),
  localparam int EW     = ACC_W + 1
) (
  input  logic [TAPS*DATA_W-1:0] taps,
  input  logic [TAPS*COEF_W-1:0] coefs,
  output logic [DATA_W-1:0]      result
);
  localparam logic signed [EW-1:0] HALF = EW'(1) <<< (FRAC - 1);
  localparam logic signed [EW-1:0] MAXV = (EW'(1) <<< (DATA_W - 1)) - EW'(1);
  localparam logic signed [EW-1:0] MINV = -(EW'(1) <<< (DATA_W - 1));

  logic signed [PROD_W-1:0] prod [TAPS];

  for (genvar k = 0; k < TAPS; k++) begin : g_mul
    assign prod[k] = $signed(taps[k*DATA_W +: DATA_W]) * $signed(coefs[k*COEF_W +: COEF_W]);
  end

  logic signed [ACC_W-1:0] acc;
  logic signed [EW-1:0]    rounded;

  always_comb begin
    acc = '0;
    for (int k = 0; k < TAPS; k++) acc = acc + ACC_W'(prod[k]);
    rounded = (EW'(acc) + HALF) >>> FRAC;
    if (rounded > MAXV)      result = MAXV[DATA_W-1:0];
    else if (rounded < MINV) result = MINV[DATA_W-1:0];
    else                     result = rounded[DATA_W-1:0];
  end
endmodule

// File: rtl/polyphase_interp4.sv
module polyphase_interp4
  import interp4_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int COEF_W = DEF_COEF_W,
  parameter int FACTOR = DEF_FACTOR,
  parameter int TAPS   = DEF_TAPS,
  parameter int FRAC   = DEF_FRAC,
  localparam int ADDR_W = $clog2(FACTOR * TAPS),
  localparam int PH_W   = $clog2(FACTOR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              coef_we,
  input  logic [ADDR_W-1:0] coef_addr,
  input  logic [COEF_W-1:0] coef_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic [PH_W-1:0]        phase;
  logic                   run;
  logic [TAPS*COEF_W-1:0] branch_coefs;
  logic [TAPS*DATA_W-1:0] taps;
  logic [DATA_W-1:0]      mac_res;

  interp4_phase_ctrl #(.FACTOR(FACTOR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(in_valid), .phase(phase), .run(run)
  );

  interp4_coef_bank #(.COEF_W(COEF_W), .FACTOR(FACTOR), .TAPS(TAPS)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(coef_we), .waddr(coef_addr), .wdata(coef_data),
    .phase(phase), .branch_coefs(branch_coefs)
  );

  interp4_tap_line #(.DATA_W(DATA_W), .TAPS(TAPS)) u_line (
    .clk(clk), .rst_n(rst_n), .shift(in_valid), .din(in_data), .taps(taps)
  );

  interp4_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .TAPS(TAPS), .FRAC(FRAC)) u_mac (
    .taps(taps), .coefs(branch_coefs), .result(mac_res)
  );

  logic              valid_q, valid_d;
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    valid_d = run;
    data_d  = mac_res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (run) data_q <= data_d;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;

  // R6 R7
  valid_follows_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(run));
  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> $stable(out_data));
endmodule

// File: tb/polyphase_interp4_test.sv
module polyphase_interp4_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [17:0] in_data;
  logic        coef_we;
  logic [3:0]  coef_addr;
  logic [17:0] coef_data;
  logic        out_valid;
  logic [17:0] out_data;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  longint hm [16];
  longint xh [4];

  localparam logic signed [17:0] COEFS [16] = '{
    18'sd1200, -18'sd3400, 18'sd5100, 18'sd800, 18'sd20000, 18'sd31000, -18'sd15000, 18'sd9000,
    18'sd45000, -18'sd7000, 18'sd12000, 18'sd60000, -18'sd2500, 18'sd4000, 18'sd700, -18'sd90000};
  localparam logic signed [17:0] STIM [12] = '{
    18'sd1000, -18'sd2000, 18'sd30000, 18'sd131071, -18'sd131072, 18'sd0,
    18'sd77, -18'sd5, 18'sd65000, -18'sd40000, 18'sd12345, 18'sd99999};

  polyphase_interp4 uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #5 clk = ~clk;

  function automatic longint expect_br(int p);
    longint s = 0;
    longint r;
    for (int k = 0; k < 4; k++) s += hm[p + 4*k] * xh[k];
    r = (s + 65536) >>> 17;
    if (r > 131071) r = 131071;
    if (r < -131072) r = -131072;
    return r;
  endfunction

  task automatic check(string req, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_out(string req, int p);
    check({req, " valid"}, longint'(out_valid), 1);
    check(req, longint'($signed(out_data)), expect_br(p));
  endtask

  task automatic write_coef(int a, longint v);
    @(negedge clk);
    coef_we = 1'b1; coef_addr = 4'(a); coef_data = 18'(v);
    @(negedge clk);
    coef_we = 1'b0;
    hm[a] = v;
  endtask

  task automatic shift_model(longint x);
    for (int k = 3; k > 0; k--) xh[k] = xh[k-1];
    xh[0] = x;
  endtask

  // Single sample then idle; called at a negedge, returns at a negedge
  task automatic push_one(longint x, string req);
    in_valid = 1'b1; in_data = 18'(x);
    @(negedge clk);
    in_valid = 1'b0;
    shift_model(x);
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      check_out(req, p);
    end
    @(negedge clk);
    check("R7 valid drop", longint'(out_valid), 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) hm[i] = 0;
    for (int i = 0; i < 4; i++) xh[i] = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    coef_we = 1'b0; coef_addr = '0; coef_data = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 valid in reset", longint'(out_valid), 0);
    check("R1 data in reset", longint'(out_data), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 valid idle", longint'(out_valid), 0);
    check("R1 data idle", longint'(out_data), 0);

    // R2 load coefficients
    for (int i = 0; i < 16; i++) write_coef(i, longint'(COEFS[i]));

    // R3 R4 R6: table-driven continuous stream
    @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      in_valid = 1'b1; in_data = STIM[i];
      @(negedge clk);
      in_valid = 1'b0;
      if (i > 0) check_out("R6 R3 branch3 stream", 3);
      shift_model(longint'(STIM[i]));
      for (int p = 0; p < 3; p++) begin
        @(negedge clk);
        check_out("R4 R3 stream", p);
      end
    end
    @(negedge clk);
    check_out("R4 branch3 last", 3);
    @(negedge clk);
    check("R7 valid drop", longint'(out_valid), 0);
    check("R7 data hold", longint'($signed(out_data)), expect_br(3));

    // R5: long idle, history must not move
    repeat (20) @(negedge clk);
    push_one(500, "R5 history held");

    // R2: rewrite one coefficient, impulse shows it
    for (int i = 0; i < 16; i++) write_coef(i, 0);
    write_coef(2, 131071);
    write_coef(6, -4096);
    @(negedge clk);
    push_one(1000, "R2 impulse");
    push_one(0, "R2 impulse delayed");

    // R8 rounding
    for (int i = 0; i < 16; i++) write_coef(i, 0);
    write_coef(0, 1);
    @(negedge clk);
    for (int i = 0; i < 4; i++) xh[i] = 0;
    push_one(0, "R8 clear"); push_one(0, "R8 clear"); push_one(0, "R8 clear");
    push_one(65536, "R8 half up");
    check("R8 65536 rounds to 1", expect_br(0), 1);
    push_one(65535, "R8 below half");
    push_one(-65536, "R8 neg half");
    push_one(-65537, "R8 neg below half");

    // R9 saturation
    for (int i = 0; i < 16; i++) write_coef(i, 131071);
    @(negedge clk);
    push_one(131071, "R9 pos"); push_one(131071, "R9 pos"); push_one(131071, "R9 pos");
    push_one(131071, "R9 pos sat");
    check("R9 pos sat value", longint'($signed(out_data)), 131071);
    push_one(-131072, "R9"); push_one(-131072, "R9"); push_one(-131072, "R9");
    push_one(-131072, "R9 neg sat");
    check("R9 neg sat value", longint'($signed(out_data)), -131072);

    // R10 early strobe restarts at branch 0
    for (int i = 0; i < 16; i++) write_coef(i, longint'(COEFS[i]));
    @(negedge clk);
    in_valid = 1'b1; in_data = 18'sd3000;
    @(negedge clk);
    in_valid = 1'b0;
    shift_model(3000);
    @(negedge clk);
    check_out("R10 before restart", 0);
    in_valid = 1'b1; in_data = -18'sd700;
    @(negedge clk);
    in_valid = 1'b0;
    check_out("R10 branch1 before restart", 1);
    shift_model(-700);
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      check_out("R10 restart order", p);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule